// File: doc/BRIEF.md
# Operand Modifier and Routing Stage

This stage sits between instruction decode and the execution units and produces the two final source operands of an instruction. Each source specifier can be used in one of three ways. It can name a register, whose value comes either from the register file read data or from a matching in-flight result bus. It can stand for itself as a small unsigned immediate. It can be replaced by a constant carried in the instruction words that follow the opcode. Either operand may also be negated in two's complement.

A five-bit modifier field drives the choice. Bit 0 marks source 1 as a non-register operand and bit 1 does the same for source 2. Bit 2 negates source 1 and bit 3 negates source 2. Bit 4 requests a trailing constant. The constant goes to source 1 if bit 0 is set, otherwise to source 2 if bit 1 is set, and otherwise no constant is taken. A separate decoded flag selects a 32-bit constant or a 64-bit constant. The constant path and the small-immediate path do not depend on the forwarding compare, so they are evaluated in parallel with it. Any operand that is not a register blocks forwarding, so no result bus can overwrite it.

The stage has a single register stage. It also reports how many 32-bit trailing words the instruction used, so that fetch can advance past them.

Top module: `opr_route_stage`

## Requirements
- R1: While reset is asserted, out_valid, out_op1, out_op2 and out_words are all zero. Reset is active low and asynchronous.
- R2: Outputs update one clock after an input cycle with in_valid high, and out_valid equals in_valid delayed by one clock. A cycle with in_valid low leaves out_op1, out_op2 and out_words unchanged.
- R3: A source with its non-register bit (in_mod[0] for source 1, in_mod[1] for source 2) clear, and no forwarding hit, takes its register read data.
- R4: A source with its non-register bit set, when in_mod[4] is clear or the constant goes to the other source, takes its specifier value zero-extended to 64 bits.
- R5: in_mod[2] (source 1) and in_mod[3] (source 2) negate the selected value in two's complement. Negating 0x8000_0000_0000_0000 gives the same value back.
- R6: When in_mod[4] is set and in_const64 is 0, the constant is in_tail[31:0] sign-extended to 64 bits. It goes to source 1 if in_mod[0] is set, else to source 2 if in_mod[1] is set. If both bits are clear, no constant is used.
- R7: When in_mod[4] is set and in_const64 is 1, the constant is all of in_tail: the first following word is in bits 31:0 and the second is in bits 63:32.
- R8: out_words is 0 when no constant is used, 1 for a 32-bit constant and 2 for a 64-bit constant.
- R9: A register source whose specifier equals fwd_spec[i] while fwd_valid[i] is high takes fwd_data[i] in place of the register data. When several buses match, the lowest index wins.
- R10: A source that is a small immediate or a constant ignores every forwarding bus, even when a bus matches its specifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_mod | input | 5 | Operand modifier bits |
| in_const64 | input | 1 | Trailing constant is 64-bit when set, 32-bit when clear |
| in_spec1 | input | SPEC_W | Source 1 specifier |
| in_spec2 | input | SPEC_W | Source 2 specifier |
| in_tail | input | DATA_W | The two instruction words that follow the opcode, first word in the low half |
| rf_data1 | input | DATA_W | Register file read data for source 1 |
| rf_data2 | input | DATA_W | Register file read data for source 2 |
| fwd_valid | input | NFWD | Result bus valid flags |
| fwd_spec | input | NFWD x SPEC_W | Result bus destination specifiers |
| fwd_data | input | NFWD x DATA_W | Result bus values |
| out_valid | output | 1 | Final operands are valid |
| out_op1 | output | DATA_W | Final source 1 operand |
| out_op2 | output | DATA_W | Final source 2 operand |
| out_words | output | 2 | Trailing 32-bit words used |

## Verification
The bound checker tests on every cycle that the output valid flag trails its input by one cycle and that the outputs hold through idle cycles. It also checks the word count against the modifier bits and constant size, and the source 1 value for three cases: a plain immediate, a trailing constant of either size, and a register read with every forwarding bus idle. The bench vectors cover what needs chosen data. That includes the wrap when the most negative value is negated, the lowest-index bus winning when several buses match, and a matching bus being ignored when the source is a constant. It also covers the constant target moving to source 2, both modifier bits being set together, and a constant request that is dropped because no target bit is set.

// File: rtl/opr_pkg.sv
package opr_pkg;
   localparam int MOD_W = 5;

   // modifier bit positions
   localparam int MB_NREG1 = 0;
   localparam int MB_NREG2 = 1;
   localparam int MB_NEG1  = 2;
   localparam int MB_NEG2  = 3;
   localparam int MB_CONST = 4;

   localparam int NUM_SRC = 2;

   typedef enum logic [1:0] {
      WORDS_NONE = 2'd0,
      WORDS_ONE  = 2'd1,
      WORDS_TWO  = 2'd2
   } tail_use_e;
endpackage

// File: rtl/opr_const_sel.sv
module opr_const_sel
   import opr_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              take_i,
   input  logic              nreg1_i,
   input  logic              nreg2_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] tail_i,
   output logic [DATA_W-1:0] const_o,
   output logic              hit1_o,
   output logic              hit2_o,
   output tail_use_e         words_o
);
   localparam int WORD_W = DATA_W / 2;

   logic [DATA_W-1:0] narrow_ext;

   // a narrow constant is sign-extended from the first trailing word
   assign narrow_ext = {{(DATA_W-WORD_W){tail_i[WORD_W-1]}}, tail_i[WORD_W-1:0]};

   always_comb begin
      hit1_o  = take_i & nreg1_i;
      hit2_o  = take_i & nreg2_i & ~nreg1_i;
      const_o = wide_i ? tail_i : narrow_ext;
      if (!(hit1_o | hit2_o))
         words_o = WORDS_NONE;
      else if (wide_i)
         words_o = WORDS_TWO;
      else
         words_o = WORDS_ONE;
   end
endmodule

// File: rtl/opr_fwd_match.sv
module opr_fwd_match #(
   parameter int NFWD   = 2,
   parameter int SPEC_W = 5,
   parameter int DATA_W = 64
) (
   input  logic [SPEC_W-1:0]            spec_i,
   input  logic [DATA_W-1:0]            rf_data_i,
   input  logic                         block_i,
   input  logic [NFWD-1:0]              fwd_valid_i,
   input  logic [NFWD-1:0][SPEC_W-1:0]  fwd_spec_i,
   input  logic [NFWD-1:0][DATA_W-1:0]  fwd_data_i,
   output logic [DATA_W-1:0]            data_o
);
   logic [NFWD-1:0] hit;

   for (genvar b = 0; b < NFWD; b++) begin : g_cmp
      assign hit[b] = fwd_valid_i[b] & (fwd_spec_i[b] == spec_i) & ~block_i;
   end

   // walk from the highest index down so the lowest matching bus wins
   always_comb begin
      data_o = rf_data_i;
      for (int b = NFWD - 1; b >= 0; b--) begin
         if (hit[b]) data_o = fwd_data_i[b];
      end
   end
endmodule

// File: rtl/opr_form.sv
module opr_form #(
   parameter int SPEC_W = 5,
   parameter int DATA_W = 64
) (
   input  logic [SPEC_W-1:0] spec_i,
   input  logic [DATA_W-1:0] reg_val_i,
   input  logic [DATA_W-1:0] const_i,
   input  logic              nreg_i,
   input  logic              use_const_i,
   input  logic              negate_i,
   output logic [DATA_W-1:0] value_o
);
   logic [DATA_W-1:0] base;

   always_comb begin
      if (use_const_i)
         base = const_i;
      else if (nreg_i)
         base = {{(DATA_W-SPEC_W){1'b0}}, spec_i};
      else
         base = reg_val_i;
      value_o = negate_i ? (~base + {{(DATA_W-1){1'b0}}, 1'b1}) : base;
   end
endmodule

// File: rtl/opr_route_stage.sv
module opr_route_stage
   import opr_pkg::*;
#(
   parameter int NFWD   = 2,
   parameter int SPEC_W = 5,
   parameter int DATA_W = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [MOD_W-1:0]            in_mod,
   input  logic                        in_const64,
   input  logic [SPEC_W-1:0]           in_spec1,
   input  logic [SPEC_W-1:0]           in_spec2,
   input  logic [DATA_W-1:0]           in_tail,
   input  logic [DATA_W-1:0]           rf_data1,
   input  logic [DATA_W-1:0]           rf_data2,
   input  logic [NFWD-1:0]             fwd_valid,
   input  logic [NFWD-1:0][SPEC_W-1:0] fwd_spec,
   input  logic [NFWD-1:0][DATA_W-1:0] fwd_data,
   output logic                        out_valid,
   output logic [DATA_W-1:0]           out_op1,
   output logic [DATA_W-1:0]           out_op2,
   output logic [1:0]                  out_words
);
   if (NFWD < 1) begin : g_bad_nfwd
      $error("opr_route_stage: NFWD must be at least 1");
   end
   if (DATA_W % 2 != 0 || DATA_W < 2 * SPEC_W) begin : g_bad_width
      $error("opr_route_stage: DATA_W must be even and hold two specifiers");
   end
   if (SPEC_W < 1) begin : g_bad_spec
      $error("opr_route_stage: SPEC_W must be positive");
   end

   logic [NUM_SRC-1:0][SPEC_W-1:0] spec;
   logic [NUM_SRC-1:0][DATA_W-1:0] rf_val;
   logic [NUM_SRC-1:0][DATA_W-1:0] fwd_val;
   logic [NUM_SRC-1:0][DATA_W-1:0] final_val;
   logic [NUM_SRC-1:0]             nreg;
   logic [NUM_SRC-1:0]             neg;
   logic [NUM_SRC-1:0]             const_hit;
   logic [DATA_W-1:0]              const_val;
   tail_use_e                      words;

   assign spec   = {in_spec2, in_spec1};
   assign rf_val = {rf_data2, rf_data1};
   assign nreg   = {in_mod[MB_NREG2], in_mod[MB_NREG1]};
   assign neg    = {in_mod[MB_NEG2], in_mod[MB_NEG1]};

   opr_const_sel #(.DATA_W(DATA_W)) u_const (
      .take_i  (in_mod[MB_CONST]),
      .nreg1_i (in_mod[MB_NREG1]),
      .nreg2_i (in_mod[MB_NREG2]),
      .wide_i  (in_const64),
      .tail_i  (in_tail),
      .const_o (const_val),
      .hit1_o  (const_hit[0]),
      .hit2_o  (const_hit[1]),
      .words_o (words)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      opr_fwd_match #(.NFWD(NFWD), .SPEC_W(SPEC_W), .DATA_W(DATA_W)) u_fwd (
         .spec_i      (spec[s]),
         .rf_data_i   (rf_val[s]),
         .block_i     (nreg[s]),
         .fwd_valid_i (fwd_valid),
         .fwd_spec_i  (fwd_spec),
         .fwd_data_i  (fwd_data),
         .data_o      (fwd_val[s])
      );

      opr_form #(.SPEC_W(SPEC_W), .DATA_W(DATA_W)) u_form (
         .spec_i      (spec[s]),
         .reg_val_i   (fwd_val[s]),
         .const_i     (const_val),
         .nreg_i      (nreg[s]),
         .use_const_i (const_hit[s]),
         .negate_i    (neg[s]),
         .value_o     (final_val[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_op1   <= '0;
         out_op2   <= '0;
         out_words <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_op1   <= final_val[0];
            out_op2   <= final_val[1];
            out_words <= words;
         end
      end
   end
endmodule

// File: rtl/opr_route_chk.sv
module opr_route_chk #(
   parameter int NFWD   = 2,
   parameter int SPEC_W = 5,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [4:0]        in_mod,
   input logic              in_const64,
   input logic [SPEC_W-1:0] in_spec1,
   input logic [DATA_W-1:0] in_tail,
   input logic [DATA_W-1:0] rf_data1,
   input logic [NFWD-1:0]   fwd_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_op1,
   input logic [DATA_W-1:0] out_op2,
   input logic [1:0]        out_words
);
   localparam int WORD_W = DATA_W / 2;

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(in_valid));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_op1) && $stable(out_op2) && $stable(out_words));

   assert_no_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_mod[4] |=> out_words == 2'd0);

   assert_tail_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mod[4] && (in_mod[0] || in_mod[1])
      |=> out_words == ($past(in_const64) ? 2'd2 : 2'd1));

   assert_small_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mod[0] && !in_mod[4] && !in_mod[2]
      |=> out_op1 == {{(DATA_W-SPEC_W){1'b0}}, $past(in_spec1)});

   assert_narrow_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mod[4] && in_mod[0] && !in_const64 && !in_mod[2]
      |=> out_op1 == {{(DATA_W-WORD_W){$past(in_tail[WORD_W-1])}},
                      $past(in_tail[WORD_W-1:0])});

   assert_wide_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_mod[4] && in_mod[0] && in_const64 && !in_mod[2]
      |=> out_op1 == $past(in_tail));

   assert_reg_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_mod[0] && !in_mod[2] && fwd_valid == '0
      |=> out_op1 == $past(rf_data1));
endmodule

bind opr_route_stage opr_route_chk #(
   .NFWD(NFWD), .SPEC_W(SPEC_W), .DATA_W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_mod     (in_mod),
   .in_const64 (in_const64),
   .in_spec1   (in_spec1),
   .in_tail    (in_tail),
   .rf_data1   (rf_data1),
   .fwd_valid  (fwd_valid),
   .out_valid  (out_valid),
   .out_op1    (out_op1),
   .out_op2    (out_op2),
   .out_words  (out_words)
);

// File: tb/tb_opr_route_stage.sv
module tb_opr_route_stage;
   localparam int NFWD = 2;
   localparam int SW   = 5;
   localparam int DW   = 64;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic [4:0]              in_mod = '0;
   logic                    in_const64 = 1'b0;
   logic [SW-1:0]           in_spec1 = '0, in_spec2 = '0;
   logic [DW-1:0]           in_tail = '0, rf_data1 = '0, rf_data2 = '0;
   logic [NFWD-1:0]         fwd_valid = '0;
   logic [NFWD-1:0][SW-1:0] fwd_spec = '0;
   logic [NFWD-1:0][DW-1:0] fwd_data;
   logic                    out_valid;
   logic [DW-1:0]           out_op1, out_op2;
   logic [1:0]              out_words;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign fwd_data[0] = 64'h0000_0000_0000_F0F0;
   assign fwd_data[1] = 64'h0000_0000_0000_F1F1;

   opr_route_stage #(.NFWD(NFWD), .SPEC_W(SW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mod(in_mod),
      .in_const64(in_const64), .in_spec1(in_spec1), .in_spec2(in_spec2),
      .in_tail(in_tail), .rf_data1(rf_data1), .rf_data2(rf_data2),
      .fwd_valid(fwd_valid), .fwd_spec(fwd_spec), .fwd_data(fwd_data),
      .out_valid(out_valid), .out_op1(out_op1), .out_op2(out_op2),
      .out_words(out_words)
   );

   typedef struct packed {
      logic [4:0]  md;
      logic        c64;
      logic [4:0]  s1;
      logic [4:0]  s2;
      logic [63:0] tail;
      logic [63:0] r1;
      logic [63:0] r2;
      logic [1:0]  fv;
      logic [4:0]  f0;
      logic [4:0]  f1;
      logic [63:0] e1;
      logic [63:0] e2;
      logic [1:0]  ew;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      // R3 plain register reads
      '{5'b00000, 1'b0, 5'd3, 5'd4, 64'h0, 64'h11, 64'h22, 2'b00, 5'd0, 5'd0,
        64'h11, 64'h22, 2'd0, 8'd3},
      // R4 and R10 small immediates, buses match but are ignored
      '{5'b00011, 1'b0, 5'd7, 5'd31, 64'h0, 64'h1, 64'h2, 2'b11, 5'd7, 5'd31,
        64'd7, 64'd31, 2'd0, 8'd4},
      // R5 negate registers, most negative wraps
      '{5'b01100, 1'b0, 5'd1, 5'd2, 64'h0, 64'd5, 64'h8000_0000_0000_0000, 2'b00, 5'd0, 5'd0,
        64'hFFFF_FFFF_FFFF_FFFB, 64'h8000_0000_0000_0000, 2'd0, 8'd5},
      // R5 negate immediate
      '{5'b00101, 1'b0, 5'd9, 5'd2, 64'h0, 64'h0, 64'h33, 2'b00, 5'd0, 5'd0,
        64'hFFFF_FFFF_FFFF_FFF7, 64'h33, 2'd0, 8'd5},
      // R6 and R8 negative narrow constant on source 1
      '{5'b10001, 1'b0, 5'd1, 5'd2, 64'hDEAD_BEEF_8000_0001, 64'h0, 64'h44, 2'b00, 5'd0, 5'd0,
        64'hFFFF_FFFF_8000_0001, 64'h44, 2'd1, 8'd6},
      // R6 narrow constant routed to source 2
      '{5'b10010, 1'b0, 5'd1, 5'd2, 64'hFFFF_FFFF_1234_5678, 64'h55, 64'h0, 2'b00, 5'd0, 5'd0,
        64'h55, 64'h0000_0000_1234_5678, 2'd1, 8'd6},
      // R7 and R10 wide constant, matching bus ignored
      '{5'b10001, 1'b1, 5'd2, 5'd6, 64'hCAFE_0001_0000_0002, 64'h0, 64'h66, 2'b01, 5'd2, 5'd0,
        64'hCAFE_0001_0000_0002, 64'h66, 2'd2, 8'd7},
      // R9 both buses match source 1, lowest wins
      '{5'b00000, 1'b0, 5'd4, 5'd5, 64'h0, 64'h0, 64'h77, 2'b11, 5'd4, 5'd4,
        64'h0000_0000_0000_F0F0, 64'h77, 2'd0, 8'd9},
      // R9 upper bus forwards to source 2
      '{5'b00000, 1'b0, 5'd4, 5'd5, 64'h0, 64'h88, 64'h0, 2'b10, 5'd0, 5'd5,
        64'h88, 64'h0000_0000_0000_F1F1, 2'd0, 8'd9},
      // R6 constant request with no target is dropped
      '{5'b10000, 1'b0, 5'd1, 5'd2, 64'h1234, 64'h99, 64'hAA, 2'b00, 5'd0, 5'd0,
        64'h99, 64'hAA, 2'd0, 8'd6},
      // R6 both targets set: constant to source 1, immediate on source 2
      '{5'b10011, 1'b0, 5'd1, 5'd12, 64'h0000_0000_7FFF_FFFF, 64'h0, 64'h0, 2'b00, 5'd0, 5'd0,
        64'h7FFF_FFFF, 64'd12, 2'd1, 8'd6},
      // R5 and R7 negated wide constant on source 2
      '{5'b11010, 1'b1, 5'd1, 5'd2, 64'h0000_0000_0000_0001, 64'h10, 64'h0, 2'b00, 5'd0, 5'd0,
        64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 8'd7}
   };

   task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      string tag;
      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid", {63'd0, out_valid}, 64'd0);
      check("R1 op1", out_op1, 64'd0);
      check("R1 op2", out_op2, 64'd0);
      check("R1 words", {62'd0, out_words}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         in_valid    = 1'b1;
         in_mod      = VT[i].md;
         in_const64  = VT[i].c64;
         in_spec1    = VT[i].s1;
         in_spec2    = VT[i].s2;
         in_tail     = VT[i].tail;
         rf_data1    = VT[i].r1;
         rf_data2    = VT[i].r2;
         fwd_valid   = VT[i].fv;
         fwd_spec[0] = VT[i].f0;
         fwd_spec[1] = VT[i].f1;
         @(posedge clk);
         #1;
         tag = $sformatf("R%0d vec%0d", VT[i].rq, i);
         check({tag, " op1"}, out_op1, VT[i].e1);
         check({tag, " op2"}, out_op2, VT[i].e2);
         check({"R8 ", tag, " words"}, {62'd0, out_words}, {62'd0, VT[i].ew});
         check({"R2 ", tag, " valid"}, {63'd0, out_valid}, 64'd1);
      end

      // R2 idle cycle: outputs hold, valid drops
      in_valid = 1'b0;
      in_mod   = 5'b00000;
      rf_data1 = 64'hBAD;
      rf_data2 = 64'hBAD;
      @(posedge clk);
      #1;
      check("R2 idle valid", {63'd0, out_valid}, 64'd0);
      check("R2 idle op1", out_op1, 64'h10);
      check("R2 idle op2", out_op2, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R2 idle words", {62'd0, out_words}, 64'd2);

      // R9 forwarding resumes after idle; bus 1 only matches source 1
      in_valid    = 1'b1;
      in_spec1    = 5'd9;
      in_spec2    = 5'd10;
      fwd_valid   = 2'b10;
      fwd_spec[1] = 5'd9;
      @(posedge clk);
      #1;
      check("R9 resume op1", out_op1, 64'h0000_0000_0000_F1F1);
      check("R3 resume op2", out_op2, 64'hBAD);

      // R1 asynchronous reset clears outputs at once
      #2;
      rst_n = 1'b0;
      #1;
      check("R1 async valid", {63'd0, out_valid}, 64'd0);
      check("R1 async op1", out_op1, 64'd0);
      check("R1 async words", {62'd0, out_words}, 64'd0);
      finish_run();
   end
endmodule